// File: doc/BRIEF.md
# Deferred Condition Code Evaluator

This block turns a recorded operation into condition flags and merges them into a status word. An execution unit that postpones flag computation records five things for its last flag-setting operation: the kind of operation, the operand size, the source operand, the destination operand and the result. It also keeps the high half of a multiply. When the flags are needed, it presents that record to this block together with the current status word, the current extend (X) flag and a write mask. The updated status word appears one clock later. The block does not compute arithmetic results. It only classifies the results it is given.

The input is a single-beat stream. A beat is accepted in every cycle where `in_valid` is high. The block never applies back-pressure, so there is no ready signal. The caller must hold nothing beyond the accepting edge. Each accepted beat produces exactly one output beat, marked by `out_valid`, in the following cycle. The output register keeps its value while no beat is accepted.

Top module: `ccev_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `stat_out` is zero and `out_valid` is low.
- R2: Status bit positions are fixed as follows: C=0, V=1, Z=2, N=3, X=4, R=8. Operation codes are ADD=0, ADDC=1, SUB=2, CMP=3, MOVE=4, AND=5, OR=6, XOR=7, ASR=8, LSR=9, LSL=10, MULS=11, MULU=12, MCP=13 and LIVE=14. Codes 0 to 3 and 15 use the sign table. For the sign table, when the result sign bit is set: N=1, V is set if both operand signs are clear, and C is set if both operand signs are set.
- R3: For the sign table, when the result sign bit is clear: Z is set if the result masked to the operand size is zero, V is set if both operand signs are set, and C is set if either operand sign is set.
- R4: For SUB and CMP, the source is bit-inverted before the sign table is consulted, and the resulting C is then inverted.
- R5: Size code 0 selects byte width (sign bit 7, Z over bits 7:0). Code 1 selects halfword width (bit 15, bits 15:0). Codes 2 and 3 select word width (bit 31, all bits).
- R6: MCP uses the sign table without source inversion. The carry-position outcome goes to R, and C is computed as 0.
- R7: MOVE, AND, OR, XOR, ASR, LSR and LSL at halfword or word size derive only N (result sign) and Z (sized result zero), with V=C=0. At byte size they use the sign table without inversion.
- R8: MULS treats {mof, res} as a 64-bit signed value. Z is set if it is zero and N if it is negative. V is set when mof differs from the sign extension of res.
- R9: MULU sets Z if {mof, res} is zero and N from bit 63. V is set whenever mof is nonzero.
- R10: If `x_in` is high or the operation is ADDC, the Z bit is dropped from the write mask, so Z keeps its value from `cur_stat`.
- R11: The output is `cur_stat` with every effective-mask bit and X cleared, then OR-ed with the new flags restricted to the effective mask. Bits outside the mask (other than X) pass through unchanged.
- R12: LIVE passes `cur_stat` through unchanged, X included. In cycles without an accepted beat, `stat_out` holds its value.
- R13: An accepted beat updates `stat_out` and raises `out_valid` for one cycle at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Beat accepted this cycle |
| op | input | 4 | Operation code |
| size | input | 2 | Operand size code |
| src | input | 32 | Recorded source operand |
| dst | input | 32 | Recorded destination operand |
| res | input | 32 | Recorded result |
| mof | input | 32 | High half of the multiply product |
| x_in | input | 1 | Current extend flag |
| wmask | input | 16 | Flags this operation may write |
| cur_stat | input | 16 | Current status word |
| out_valid | output | 1 | Output beat present |
| stat_out | output | 16 | Updated status word |

## Verification
Additions are run with both operand signs clear and a negative result to isolate V. They are also run with both signs set and a zero result to isolate C and Z. Subtract and compare are run with equal operands and with a borrow, which tells the inverted carry sense apart from the plain one. Byte, halfword and word results are chosen with bits set only above the selected width. This separates the three sign and zero positions. Multiply cases pair a high half that is the sign extension of the result with one that is not, which distinguishes the signed overflow rule from the unsigned one. Partial masks, a live pass-through, a set X input and idle cycles show which status bits may change.

// File: rtl/ccev_pkg.sv
package ccev_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_CMP  = 4'd3,
    OP_MOVE = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_ASR  = 4'd8,
    OP_LSR  = 4'd9,
    OP_LSL  = 4'd10,
    OP_MULS = 4'd11,
    OP_MULU = 4'd12,
    OP_MCP  = 4'd13,
    OP_LIVE = 4'd14,
    OP_RSV  = 4'd15
  } ccop_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;

endpackage

// File: rtl/ccev_signtab.sv
module ccev_signtab
  import ccev_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]    size,
  input  logic          inv_src,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  input  logic [DW-1:0] res,
  output nzvc_t         flags
);
  localparam int SBW = $clog2(DW);

  logic [DW-1:0]  s_eff;
  logic [SBW-1:0] sbit;
  logic [DW-1:0]  zmask;
  logic           sn, dn, rn, rz;

  always_comb begin
    s_eff = inv_src ? ~src : src;
    case (size)
      SZ_BYTE: begin sbit = SBW'(7);      zmask = DW'(8'hFF);     end
      SZ_HALF: begin sbit = SBW'(15);     zmask = DW'(16'hFFFF);  end
      default: begin sbit = SBW'(DW - 1); zmask = '1;             end
    endcase
    sn = s_eff[sbit];
    dn = dst[sbit];
    rn = res[sbit];
    rz = ((res & zmask) == '0);
    flags = '0;
    if (rn) begin
      flags.n = 1'b1;
      flags.v = !sn && !dn;
      flags.c = sn && dn;
    end else begin
      flags.z = rz;
      flags.v = sn && dn;
      flags.c = sn || dn;
    end
  end
endmodule

// File: rtl/ccev_nz.sv
module ccev_nz
  import ccev_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]    size,
  input  logic [DW-1:0] res,
  output nzvc_t         flags
);
  always_comb begin
    flags = '0;
    if (size == SZ_HALF) begin
      flags.n = res[15];
      flags.z = (res[15:0] == 16'h0);
    end else begin
      flags.n = res[DW-1];
      flags.z = (res == '0);
    end
  end
endmodule

// File: rtl/ccev_mul.sv
module ccev_mul
  import ccev_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          signed_mode,
  input  logic [DW-1:0] mof,
  input  logic [DW-1:0] res,
  output nzvc_t         flags
);
  logic [2*DW-1:0] prod;

  always_comb begin
    prod    = {mof, res};
    flags   = '0;
    flags.z = (prod == '0);
    flags.n = prod[2*DW-1];
    if (signed_mode)
      flags.v = res[DW-1] ? (mof != '1) : (mof != '0);
    else
      flags.v = (mof != '0);
  end
endmodule

// File: rtl/ccev_top.sv
module ccev_top
  import ccev_pkg::*;
#(
  parameter int DW    = 32,
  parameter int SW    = 16,
  parameter int C_POS = 0,
  parameter int V_POS = 1,
  parameter int Z_POS = 2,
  parameter int N_POS = 3,
  parameter int X_POS = 4,
  parameter int R_POS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [1:0]    size,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  input  logic [DW-1:0] res,
  input  logic [DW-1:0] mof,
  input  logic          x_in,
  input  logic [SW-1:0] wmask,
  input  logic [SW-1:0] cur_stat,
  output logic          out_valid,
  output logic [SW-1:0] stat_out
);
  localparam logic [SW-1:0] X_BIT = SW'(1) << X_POS;
  localparam logic [SW-1:0] Z_BIT = SW'(1) << Z_POS;

  ccop_e op_e;
  logic  is_sub, is_logic, is_mul, wide_logic;
  nzvc_t tab_f, nz_f, mul_f;
  logic  [SW-1:0] new_f, eff_mask, nxt_stat;

  assign op_e       = ccop_e'(op);
  assign is_sub     = (op_e == OP_SUB) || (op_e == OP_CMP);
  assign is_logic   = (op_e >= OP_MOVE) && (op_e <= OP_LSL);
  assign is_mul     = (op_e == OP_MULS) || (op_e == OP_MULU);
  assign wide_logic = is_logic && (size != SZ_BYTE);

  ccev_signtab #(.DW(DW)) u_tab (
    .size(size), .inv_src(is_sub), .src(src), .dst(dst), .res(res),
    .flags(tab_f)
  );

  ccev_nz #(.DW(DW)) u_nz (
    .size(size), .res(res), .flags(nz_f)
  );

  ccev_mul #(.DW(DW)) u_mul (
    .signed_mode(op_e == OP_MULS), .mof(mof), .res(res), .flags(mul_f)
  );

  always_comb begin
    nzvc_t sel;
    logic  carry_bit;
    new_f = '0;
    if (is_mul)          sel = mul_f;
    else if (wide_logic) sel = nz_f;
    else                 sel = tab_f;
    carry_bit = sel.c ^ is_sub;
    new_f[N_POS] = sel.n;
    new_f[Z_POS] = sel.z;
    new_f[V_POS] = sel.v;
    if (op_e == OP_MCP) new_f[R_POS] = sel.c;
    else                new_f[C_POS] = carry_bit;
  end

  always_comb begin
    eff_mask = wmask;
    if (x_in || op_e == OP_ADDC) eff_mask = wmask & ~Z_BIT;
    if (op_e == OP_LIVE) nxt_stat = cur_stat;
    else nxt_stat = (cur_stat & ~(eff_mask | X_BIT)) | (new_f & eff_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      stat_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) stat_out <= nxt_stat;
    end
  end

  // R12
  live_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_LIVE) |=> (stat_out == $past(cur_stat)));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(stat_out));

  // R11
  unmasked_keep_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (((stat_out ^ $past(cur_stat)) & ~($past(wmask) | X_BIT)) == '0));

  // R11
  x_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op != OP_LIVE) |=> !stat_out[X_POS]);

  // R10
  z_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (x_in || op == OP_ADDC)) |=> (stat_out[Z_POS] == $past(cur_stat[Z_POS])));

  // R13
  beat_out_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R3
  nz_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op != OP_LIVE && !x_in && op != OP_ADDC && wmask[N_POS] && wmask[Z_POS])
      |=> !(stat_out[N_POS] && stat_out[Z_POS]));

endmodule

// File: tb/sim_ccev_top.sv
`timescale 1ns/1ps
module sim_ccev_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  size = '0;
  logic [31:0] src = '0, dst = '0, res = '0, mof = '0;
  logic        x_in = 1'b0;
  logic [15:0] wmask = '0, cur_stat = '0;
  logic        out_valid;
  logic [15:0] stat_out;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] last_exp = '0;

  always #2 clk = ~clk;

  ccev_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
    .src(src), .dst(dst), .res(res), .mof(mof), .x_in(x_in),
    .wmask(wmask), .cur_stat(cur_stat), .out_valid(out_valid),
    .stat_out(stat_out)
  );

  function automatic logic [15:0] model(
    input logic [3:0] o, input logic [1:0] sz,
    input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
    input logic [31:0] m, input logic x, input logic [15:0] msk,
    input logic [15:0] cur);
    int w;
    logic n, z, v, c, rr, sn, dn, rn;
    logic [31:0] se;
    logic [63:0] p;
    logic [15:0] f, em;
    n = 0; z = 0; v = 0; c = 0; rr = 0;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    if (o == 4'd14) return cur;
    if (o == 4'd11 || o == 4'd12) begin
      p = {m, r};
      z = (p == 64'd0);
      n = p[63];
      if (o == 4'd11) v = r[31] ? (m != 32'hFFFF_FFFF) : (m != 32'd0);
      else            v = (m != 32'd0);
    end else if (o >= 4'd4 && o <= 4'd10 && w > 8) begin
      n = r[w-1];
      z = ((r << (32 - w)) == 32'd0);
    end else begin
      se = (o == 4'd2 || o == 4'd3) ? ~s : s;
      sn = se[w-1]; dn = d[w-1]; rn = r[w-1];
      if (rn) begin
        n = 1; v = !sn && !dn; c = sn && dn;
      end else begin
        z = ((r << (32 - w)) == 32'd0);
        v = sn && dn; c = sn || dn;
      end
      if (o == 4'd13) begin rr = c; c = 0; end
      else if (o == 4'd2 || o == 4'd3) c = !c;
    end
    f = '0;
    f[0] = c; f[1] = v; f[2] = z; f[3] = n; f[8] = rr;
    em = msk;
    if (x || o == 4'd1) em[2] = 1'b0;
    return (cur & ~(em | 16'h0010)) | (f & em);
  endfunction

  task automatic send(input string tag, input logic [3:0] o, input logic [1:0] sz,
                      input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
                      input logic [31:0] m, input logic x, input logic [15:0] msk,
                      input logic [15:0] cur);
    logic [15:0] e;
    @(negedge clk);
    in_valid = 1'b1; op = o; size = sz; src = s; dst = d; res = r; mof = m;
    x_in = x; wmask = msk; cur_stat = cur;
    e = model(o, sz, s, d, r, m, x, msk, cur);
    last_exp = e;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R13: unexpected out_valid, got 1 expected 0");
      end else begin
        check(tag_q.pop_front(), stat_out, exp_q.pop_front());
      end
    end
  end

  initial begin
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  localparam logic [15:0] ALLF = 16'h010F;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset stat", stat_out, 16'h0);
    check("R1 reset valid", {15'd0, out_valid}, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {out_valid, stat_out[14:0]}, 16'h0);

    // R2 negative result, both operand signs clear -> N,V
    send("R2 add overflow", 4'd0, 2'd2, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 0, 0, ALLF, 16'h0);
    // R2 negative result, both signs set -> N,C
    send("R2 add neg carry", 4'd0, 2'd2, 32'h8000_0000, 32'hC000_0000, 32'h8000_0001, 0, 0, ALLF, 16'h0);
    // R3 zero result, both signs set -> Z,V,C
    send("R3 add zero wrap", 4'd0, 2'd2, 32'h8000_0000, 32'h8000_0000, 32'h0, 0, 0, ALLF, 16'h0);
    // R3 positive, one sign set -> C only
    send("R3 add one sign", 4'd0, 2'd2, 32'hFFFF_FFFF, 32'h2, 32'h1, 0, 0, ALLF, 16'h0);
    // R4 equal subtract -> Z, no borrow
    send("R4 sub equal", 4'd2, 2'd2, 32'h1, 32'h1, 32'h0, 0, 0, ALLF, 16'h0);
    // R4 compare with borrow -> N,C
    send("R4 cmp borrow", 4'd3, 2'd2, 32'h2, 32'h1, 32'hFFFF_FFFF, 0, 0, ALLF, 16'h0);
    // R5 byte sign bit 7
    send("R5 byte neg", 4'd0, 2'd0, 32'h7F, 32'h01, 32'h0000_0180, 0, 0, ALLF, 16'h0);
    // R5 halfword zero with bits above
    send("R5 half zero", 4'd0, 2'd1, 32'h0, 32'h0, 32'h0001_0000, 0, 0, ALLF, 16'h0);
    // R5 byte zero with bits above
    send("R5 byte zero", 4'd0, 2'd0, 32'h0, 32'h0, 32'h0000_FF00, 0, 0, ALLF, 16'h0);
    // R6 mcp routes carry to R
    send("R6 mcp", 4'd13, 2'd2, 32'h8000_0000, 32'h0, 32'h10, 0, 0, ALLF, 16'h0001);
    // R7 word move zero, operand signs ignored
    send("R7 move word", 4'd4, 2'd2, 32'h8000_0000, 32'h8000_0000, 32'h0, 0, 0, ALLF, 16'h0);
    // R7 half shift negative
    send("R7 lsl half", 4'd10, 2'd1, 32'h8000_0000, 32'h8000_0000, 32'h0000_8000, 0, 0, ALLF, 16'h0);
    // R7 byte logical uses sign table
    send("R7 and byte", 4'd5, 2'd0, 32'h80, 32'h80, 32'h0, 0, 0, ALLF, 16'h0);
    // R8 signed multiply
    send("R8 muls neg", 4'd11, 2'd2, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 0, ALLF, 16'h0);
    send("R8 muls ovf", 4'd11, 2'd2, 0, 0, 32'h8000_0000, 32'h0, 0, ALLF, 16'h0);
    send("R8 muls zero", 4'd11, 2'd2, 0, 0, 32'h0, 32'h0, 0, ALLF, 16'h0);
    // R9 unsigned multiply
    send("R9 mulu hi", 4'd12, 2'd2, 0, 0, 32'h0, 32'h8000_0000, 0, ALLF, 16'h0);
    send("R9 mulu small", 4'd12, 2'd2, 0, 0, 32'h8000_0005, 32'h0, 0, ALLF, 16'h0);
    // R10 Z held by addc, prior Z set and clear
    send("R10 addc keep1", 4'd1, 2'd2, 32'h0, 32'h0, 32'h5, 0, 0, ALLF, 16'h0004);
    send("R10 addc keep0", 4'd1, 2'd2, 32'h0, 32'h0, 32'h0, 0, 0, ALLF, 16'h0000);
    send("R10 x set", 4'd0, 2'd2, 32'h0, 32'h0, 32'h0, 0, 1, ALLF, 16'h0000);
    // R11 partial mask, X cleared, other bits kept
    send("R11 partial", 4'd0, 2'd2, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 0, 0, 16'h0008, 16'hA037);
    // R12 live passes through including X
    send("R12 live", 4'd14, 2'd2, 0, 0, 0, 0, 0, ALLF, 16'h5A1F);
    @(negedge clk);
    in_valid = 1'b0;
    cur_stat = 16'hFFFF; op = 4'd0; wmask = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R12 idle hold", stat_out, last_exp);
    check("R13 idle valid", {15'd0, out_valid}, 16'h0);
    check("R13 drained", 16'(exp_q.size()), 16'h0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule